// File: doc/BRIEF.md
# Resettable Programmable Period Generator

This block turns a stream of master ticks into a slow square wave. A free-running tick counter supplies the timebase. A fixed power-of-two prescale is always applied, and a selectable power-of-eight ratio is applied on top of it. One 4-bit selection code chooses that ratio. The same code also chooses the polarity of the block.

The top bit of the code picks the polarity. With polarity 0, the reset pin is active high and the idle output is low. With polarity 1, the reset pin is active low and the output is inverted. The lower three bits pick the ratio, and they are mirrored when the polarity bit is set. As a result, codes 0 and 15 both give the shortest period, and codes 7 and 8 both give the longest.

The reset pin is asynchronous and is synchronized inside the block. It only holds the output latch. The tick counter keeps running while the pin is active, so pulses that resume after release stay aligned to the original phase.

Top module: `slow_period_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `out_o` is 0 after that edge and the tick counter restarts from zero.
- R2: Take no reset pin activity since `rst`, and let T be the number of edges with `tick_i` high since then. After each edge, `out_o` equals bit (PRE_BITS + STEP_BITS·k − 1) of T, XORed with the polarity bit. Here k is the ratio index. The period is therefore 2^PRE_BITS · 2^(STEP_BITS·k) ticks, which is 1024 · 8^k ticks with the defaults.
- R3: Codes 0 to 7 give polarity 0 and ratio index k equal to the code.
- R4: Codes 8 to 15 give polarity 1 (code bit 3) and ratio index k = 15 − code.
- R5: Without pin activity, the output is at its active level for exactly half of each period. The active level is high for polarity 0 and low for polarity 1.
- R6: With polarity 0, a pin at 1 forces `out_o` to 0. With polarity 1, a pin at 0 forces `out_o` to 1. A pin change takes effect on the third clock edge after it, because of two synchronizer stages and the output register.
- R7: The tick counter keeps counting while the pin holds the output. After release, the output returns to its active level only at the next boundary where the selected counter bit rises. It does not return at the release itself.
- R8: A pin pulse that is shorter than the period and arrives during the active phase cuts that phase short.
- R9: The counter advances only on edges where `tick_i` is high. With `tick_i` low, the pin inactive and the code steady, `out_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | Master tick enable; the counter advances on edges where it is high |
| code_i | input | 4 | Bit 3 is polarity; bits 2:0 are the ratio index, mirrored when bit 3 is 1 |
| rst_pin_i | input | 1 | Asynchronous output-hold pin, active level set by polarity |
| out_o | output | 1 | Registered square-wave output |

## Verification
The hardest case to reach is releasing the hold pin partway through what would have been an active phase. Only there can the design show that it waits for the next counter boundary rather than resuming the output at once. The bench keeps its own count of ticks since reset and uses it to place pin edges at chosen phases. It allows for the fixed three-edge pin latency. It then checks the output on the cycles just before and at the next expected rising boundary, and also checks the value when the truncated phase should have ended.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
  // The ratio index is three bits wide; the code adds the polarity bit on top.
  localparam int unsigned IDX_W = 3;

  typedef enum logic {
    POL_HOLD_HIGH = 1'b0,  // pin active high, output not inverted
    POL_HOLD_LOW  = 1'b1   // pin active low, output inverted
  } pol_e;

  typedef struct packed {
    pol_e             pol;
    logic [IDX_W-1:0] idx;
  } sel_t;
endpackage

// File: rtl/pg_code_map.sv
`timescale 1ns/1ps
module pg_code_map
  import pg_pkg::*;
(
  input  logic [IDX_W:0] code_i,
  output sel_t           sel_o
);
  // Upper half of the code space mirrors the ratio index (15 - code).
  always_comb begin
    sel_o.pol = pol_e'(code_i[IDX_W]);
    sel_o.idx = code_i[IDX_W] ? ~code_i[IDX_W-1:0] : code_i[IDX_W-1:0];
  end
endmodule

// File: rtl/pg_sync.sv
`timescale 1ns/1ps
module pg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pg_tick_counter.sv
`timescale 1ns/1ps
module pg_tick_counter #(
  parameter int unsigned PRE_BITS  = 10,
  parameter int unsigned STEP_BITS = 3,
  parameter int unsigned IDX_W     = 3,
  localparam int unsigned NSEL     = 1 << IDX_W,
  localparam int unsigned CNT_W    = PRE_BITS + STEP_BITS * (NSEL - 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  output logic [NSEL-1:0] rise_o,
  output logic [NSEL-1:0] fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nx;
  end

  // One boundary tap per ratio setting: the half-period bit of that ratio.
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    localparam int unsigned TAP = PRE_BITS + STEP_BITS * g - 1;
    assign rise_o[g] = tick_i & ~cnt_q[TAP] &  cnt_nx[TAP];
    assign fall_o[g] = tick_i &  cnt_q[TAP] & ~cnt_nx[TAP];
  end

  // R9: counter moves by one on a tick, and only on a tick
  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pg_out_latch.sv
`timescale 1ns/1ps
module pg_out_latch #(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned NSEL = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSEL-1:0]  rise_i,
  input  logic [NSEL-1:0]  fall_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             pol_i,
  input  logic             hold_i,
  output logic             out_o
);
  logic lat_q;
  logic lat_d;
  logic out_q;

  // The latch moves only on a boundary of the selected tap; hold clears it.
  always_comb begin
    lat_d = lat_q;
    if (hold_i)              lat_d = 1'b0;
    else if (rise_i[idx_i])  lat_d = 1'b1;
    else if (fall_i[idx_i])  lat_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      out_q <= lat_d ^ pol_i;
    end
  end

  assign out_o = out_q;

  // R6: a held latch shows the polarity level on the next edge
  assert_forced_level_R6: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (out_q == $past(pol_i)));
  // R7: the latch only rises when some tap crossed a rising boundary
  assert_rise_on_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_q) |-> $past(|rise_i));
endmodule

// File: rtl/slow_period_gen.sv
`timescale 1ns/1ps
module slow_period_gen
  import pg_pkg::*;
#(
  parameter int unsigned PRE_BITS    = 10,
  parameter int unsigned STEP_BITS   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NSEL       = 1 << IDX_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_i,
  input  logic [IDX_W:0] code_i,
  input  logic           rst_pin_i,
  output logic           out_o
);
  sel_t            sel;
  logic            pin_s;
  logic            hold;
  logic [NSEL-1:0] rise;
  logic [NSEL-1:0] fall;

  pg_code_map u_map (
    .code_i (code_i),
    .sel_o  (sel)
  );

  pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rst_pin_i),
    .q_o (pin_s)
  );

  // Polarity 1 makes the pin active low.
  assign hold = (sel.pol == POL_HOLD_LOW) ? ~pin_s : pin_s;

  pg_tick_counter #(
    .PRE_BITS  (PRE_BITS),
    .STEP_BITS (STEP_BITS),
    .IDX_W     (IDX_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  pg_out_latch #(.IDX_W(IDX_W)) u_lat (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise),
    .fall_i (fall),
    .idx_i  (sel.idx),
    .pol_i  (sel.pol),
    .hold_i (hold),
    .out_o  (out_o)
  );

  // R1: power-on reset drives the output low
  assert_power_on_low_R1: assert property (@(posedge clk)
    rst |=> (out_o == 1'b0));
  // R9: no tick, no hold, steady polarity -> output holds
  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !hold && $stable(code_i[IDX_W])) |=> $stable(out_o));
endmodule

// File: tb/sim_slow_period_gen.sv
`timescale 1ns/1ps
module sim_slow_period_gen;
  localparam int unsigned PRE  = 2;
  localparam int unsigned STEP = 1;

  // Expected period in ticks per code (PRE=2, STEP=1): 4 << index, mirrored.
  localparam int unsigned VEC_PERIOD [16] = '{4, 8, 16, 32, 64, 128, 256, 512,
                                              512, 256, 128, 64, 32, 16, 8, 4};
  localparam bit VEC_POL [16] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                  1, 1, 1, 1, 1, 1, 1, 1};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       pin = 1'b1;
  logic [3:0] code = 4'd15;
  logic       out;

  int tick_mode = 0;  // 0: every cycle, 1: every other cycle, 2: stopped
  int checks = 0;
  int errors = 0;
  int unsigned tcount;

  always #2 clk = ~clk;

  slow_period_gen #(.PRE_BITS(PRE), .STEP_BITS(STEP)) u0 (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .code_i    (code),
    .rst_pin_i (pin),
    .out_o     (out)
  );

  always @(negedge clk)
    tick <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? ~tick : 1'b0;

  // Bench-side count of ticks since power-on reset.
  always @(posedge clk)
    if (rst) tcount <= 0;
    else if (tick) tcount <= tcount + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Cycles at active level and full period, both in clock cycles.
  task automatic measure(input bit pol, output int hi, output int per);
    int lo;
    while ((out ^ pol) == 1'b1) step(1);
    while ((out ^ pol) == 1'b0) step(1);
    hi = 0;
    while ((out ^ pol) == 1'b1) begin step(1); hi++; end
    lo = 0;
    while ((out ^ pol) == 1'b0) begin step(1); lo++; end
    per = hi + lo;
  endtask

  task automatic wait_phase(input int unsigned modv, input int unsigned ph);
    while ((tcount % modv) != ph) step(1);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int hi, per;
    step(3);
    chk("R1 output low in power-on reset", out, 0);
    rst = 1'b0;

    // Vector table: every code, pin at its inactive level.
    for (int c = 0; c < 16; c++) begin
      code = 4'(c);
      pin  = VEC_POL[c];
      step(3 + VEC_PERIOD[c]);
      measure(VEC_POL[c], hi, per);
      if (c < 8) chk($sformatf("R3 period code %0d", c), per, VEC_PERIOD[c]);
      else       chk($sformatf("R4 period code %0d", c), per, VEC_PERIOD[c]);
      chk($sformatf("R5 active width code %0d", c), hi, VEC_PERIOD[c] / 2);
    end

    // R2: output tracks bit 4 of the tick count for code 3 (tap = 2+3-1).
    code = 4'd3; pin = 1'b0;
    step(40);
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
        if (out !== tcount[4]) bad++;
        step(1);
      end
      chk("R2 output equals counter tap", bad, 0);
    end

    // R6: forced levels for both polarities.
    code = 4'd1; pin = 1'b1;
    step(3);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin if (out !== 1'b0) bad++; step(1); end
      chk("R6 polarity 0 pin high forces low", bad, 0);
    end
    code = 4'd14; pin = 1'b0;
    step(3);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin if (out !== 1'b1) bad++; step(1); end
      chk("R6 polarity 1 pin low forces high", bad, 0);
    end

    // R8 / R7 with code 1: tap bit 2, period 8 ticks.
    code = 4'd1; pin = 1'b0;
    step(16);
    wait_phase(8, 4);
    chk("R5 active at rising boundary", out, 1);
    pin = 1'b1;
    step(3);
    chk("R8 short pin pulse truncates active phase", out, 0);
    wait_phase(8, 4);
    chk("R6 held at boundary", out, 0);
    pin = 1'b0;
    step(3);
    chk("R7 no resume at release", out, 0);
    step(4);
    chk("R7 still low before boundary", out, 0);
    step(1);
    chk("R7 resumes on counter boundary", out, 1);

    // R9: ticks on every other cycle double the period in clock cycles.
    code = 4'd0;
    tick_mode = 1;
    step(12);
    measure(1'b0, hi, per);
    chk("R9 period with half-rate ticks", per, 8);
    chk("R9 active width with half-rate ticks", hi, 4);

    // R9: stopped ticks freeze the output, then phase continues from count.
    tick_mode = 2;
    step(2);
    begin
      int bad = 0;
      logic held;
      held = out;
      for (int i = 0; i < 30; i++) begin if (out !== held) bad++; step(1); end
      chk("R9 output frozen without ticks", bad, 0);
    end
    tick_mode = 0;
    step(2);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin if (out !== tcount[1]) bad++; step(1); end
      chk("R9 counter paused, phase kept", bad, 0);
    end

    summary();
  end
endmodule